// File: doc/BRIEF.md
# Service Request Acknowledge Unit

This block keeps the pending service requests of a multi-channel serial controller and answers the host's acknowledges. It has three request classes: receive, transmit and modem. Each class is set by a one-cycle input pulse and is shown to the host on its own request output. The host acknowledges a request in one of two ways. It can run a hardware acknowledge bus cycle, which is passed from device to device along a daisy chain. It can also read one of three acknowledge registers, one for each class. On a served acknowledge the block returns an interrupt vector. The vector holds the programmable global vector in its upper five bits and a class code in its low three bits.

If an acknowledge finds nothing pending, the result depends on the chain setting. With chaining enabled, the block passes the acknowledge on through its active-low acknowledge output. With chaining disabled, it returns the vector with a zero code. The host can then poll devices one after another until it reads a non-zero code. The bus is synchronous: all inputs are sampled on the rising clock edge, and each data strobe is acted on once, at the first edge where it is seen low.

Top module: `svc_ack_ctrl`

## Requirements
- R1: A one-cycle pulse on a class's request input makes that class's request output high from the next clock edge. The three classes are independent of each other.
- R2: A hardware acknowledge is taken only when ack_in_n and ds_n are low and cs_n is high. With cs_n low the access is a register access, even if ack_in_n is low.
- R3: A hardware acknowledge serves the highest-priority pending class. Receive has the highest priority, then transmit, then modem.
- R4: A read at address 2 acknowledges receive, at address 3 transmit, and at address 4 modem.
- R5: A served acknowledge returns rdata = {global vector[7:3], code}. The codes are 3'b011 for receive, 3'b010 for transmit and 3'b001 for modem. rdata_valid rises at the edge where the strobe is first seen. While rdata_valid is low, rdata is zero.
- R6: An acknowledge clears the pending flag of the class it serves. A request pulse in the same cycle keeps that flag pending.
- R7: If an acknowledge finds nothing pending and chaining is enabled, ack_out_n goes low and rdata_valid stays low.
- R8: If an acknowledge finds nothing pending and chaining is disabled, rdata returns the global vector with code 3'b000 and rdata_valid high.
- R9: ack_out_n returns high in the same cycle that ds_n goes high. For a hardware acknowledge it also returns high in the same cycle that ack_in_n goes high.
- R10: Writes and reads use these registers:
  - Address 0 holds the global vector. A write keeps only wdata[7:3]. A read returns {vector, 3'b000}.
  - Address 1 holds the chain enable in bit 0. A read returns {7'b0, enable}.
  - After reset the vector is zero, chaining is disabled and nothing is pending.
- R11: A strobe held low for several cycles acknowledges only once. Requests that arrive while the strobe is held stay pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ds_n | input | 1 | Data strobe, active low |
| wr_en | input | 1 | 1 = write, 0 = read during a selected access |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| ack_in_n | input | 1 | Acknowledge from the previous device in the chain, active low |
| rx_pulse | input | 1 | Receive service request pulse |
| tx_pulse | input | 1 | Transmit service request pulse |
| mdm_pulse | input | 1 | Modem service request pulse |
| rx_req | output | 1 | Receive request pending |
| tx_req | output | 1 | Transmit request pending |
| mdm_req | output | 1 | Modem request pending |
| rdata | output | 8 | Read data or acknowledge vector |
| rdata_valid | output | 1 | rdata holds a valid value for the current strobe |
| ack_out_n | output | 1 | Acknowledge passed to the next device in the chain, active low |

## Verification
A pending flag that is wrong can be seen on its request output one edge after the pulse or acknowledge that should have changed it. The same error also shows as the wrong code, or as a chain pass-on, in the very next acknowledge. A wrong chain-enable bit or a wrong priority choice is visible on rdata or ack_out_n one edge after the strobe starts. A stale pass-on state would hold ack_out_n low after the strobe is released, and the bench checks for this in that same cycle.

// File: rtl/svc_ack_pkg.sv
// Shared constants and helpers for the service request acknowledge unit.
// Assumes class index 0 = modem, 1 = transmit, 2 = receive; code = index + 1.
package svc_ack_pkg;
    localparam int NCLS   = 3;
    localparam int CODE_W = 3;
    localparam int IDX_W  = $clog2(NCLS);

    typedef enum logic [IDX_W-1:0] {
        CLS_MDM = 2'd0,
        CLS_TX  = 2'd1,
        CLS_RX  = 2'd2
    } cls_e;

    // Turn a class index into its vector code (zero is reserved for "none").
    function automatic logic [CODE_W-1:0] cls_code(input logic [IDX_W-1:0] idx);
        return CODE_W'(idx) + CODE_W'(1);
    endfunction
endpackage

// File: rtl/svc_pend_bank.sv
// Pending flags, one for each request class.
// Assumes set and clr are single-cycle; set wins when both arrive together.
module svc_pend_bank #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] pend
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        // Hold, clear or set one class flag.
        always_ff @(posedge clk) begin
            if (!rst_n)      pend[i] <= 1'b0;
            else if (set[i]) pend[i] <= 1'b1;
            else if (clr[i]) pend[i] <= 1'b0;
        end

        assert_set_pends_R1: assert property (@(posedge clk) disable iff (!rst_n)
            set[i] |=> pend[i]);
        assert_clear_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[i] && !set[i]) |=> !pend[i]);
    end
endmodule

// File: rtl/svc_bus_decode.sv
// Host bus decode and configuration registers.
// Finds the first edge of each strobe and classifies it as a hardware acknowledge,
// a register acknowledge, a configuration read or a configuration write.
// Assumes a synchronous bus sampled on the rising edge.
module svc_bus_decode
    import svc_ack_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs_n,
    input  logic                 ds_n,
    input  logic                 ack_in_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wdata,
    output logic                 strobe_start,
    output logic                 hw_ack,
    output logic                 reg_ack,
    output logic [IDX_W-1:0]     reg_cls,
    output logic                 rd_cfg,
    output logic                 rd_gvec,
    output logic                 chain_en,
    output logic [DATA_W-CODE_W-1:0] gvec
);
    localparam int GV_W = DATA_W - CODE_W;
    localparam logic [ADDR_W-1:0] A_GVEC    = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_CFG     = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_ACK_RX  = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] A_ACK_MDM = ADDR_W'(4);

    logic              ds_prev;
    logic              sel_rd;
    logic              sel_wr;
    logic [ADDR_W-1:0] cls_diff;
    wire               unused_wbits = ^wdata[CODE_W-1:1];

    // Remember the previous strobe level so that each strobe acts once.
    always_ff @(posedge clk) begin
        if (!rst_n) ds_prev <= 1'b1;
        else        ds_prev <= ds_n;
    end

    // Classify the access at the first edge of the strobe.
    always_comb begin
        strobe_start = !ds_n && ds_prev;
        sel_rd       = strobe_start && !cs_n && !wr_en;
        sel_wr       = strobe_start && !cs_n && wr_en;
        hw_ack       = strobe_start && cs_n && !ack_in_n;
        reg_ack      = sel_rd && (addr >= A_ACK_RX) && (addr <= A_ACK_MDM);
        cls_diff     = A_ACK_MDM - addr;
        reg_cls      = cls_diff[IDX_W-1:0];
        rd_cfg       = sel_rd && (addr == A_CFG);
        rd_gvec      = sel_rd && (addr == A_GVEC);
    end

    // Configuration writes: the upper vector bits and the chain enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gvec     <= '0;
            chain_en <= 1'b0;
        end else if (sel_wr && addr == A_GVEC) begin
            gvec     <= wdata[DATA_W-1:CODE_W];
        end else if (sel_wr && addr == A_CFG) begin
            chain_en <= wdata[0];
        end
    end

    assert_one_ack_kind_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_in_n && !cs_n |-> !hw_ack);

    logic [GV_W-1:0] gvec_chk_unused;
    assign gvec_chk_unused = gvec;
endmodule

// File: rtl/svc_ack_resp.sv
// Acknowledge response: picks the class to serve, clears its flag,
// forms the vector, or passes the acknowledge down the chain.
// Assumes the decode pulses last one cycle per strobe.
module svc_ack_resp
    import svc_ack_pkg::*;
#(
    parameter int N      = 3,
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ds_n,
    input  logic                     ack_in_n,
    input  logic                     strobe_start,
    input  logic                     hw_ack,
    input  logic                     reg_ack,
    input  logic [IDX_W-1:0]         reg_cls,
    input  logic                     rd_cfg,
    input  logic                     rd_gvec,
    input  logic                     chain_en,
    input  logic [DATA_W-CODE_W-1:0] gvec,
    input  logic [N-1:0]             pend,
    output logic [N-1:0]             clr,
    output logic [DATA_W-1:0]        rdata,
    output logic                     rdata_valid,
    output logic                     ack_out_n
);
    logic [IDX_W-1:0] sel;
    logic             hit;
    logic             pass_q;
    logic             pass_hw_q;

    // Choose the class: highest pending index for hardware, the addressed class for a read.
    always_comb begin
        sel = reg_cls;
        hit = 1'b0;
        if (hw_ack) begin
            for (int i = 0; i < N; i++) begin
                if (pend[i]) begin
                    sel = IDX_W'(i);
                    hit = 1'b1;
                end
            end
        end else if (reg_ack) begin
            hit = pend[reg_cls];
        end
        clr = hit ? (N'(1) << sel) : '0;
    end

    // Capture the response at the start of the strobe and hold it until release.
    always_ff @(posedge clk) begin
        if (!rst_n || ds_n) begin
            rdata       <= '0;
            rdata_valid <= 1'b0;
            pass_q      <= 1'b0;
            pass_hw_q   <= 1'b0;
        end else if (strobe_start) begin
            if (hw_ack || reg_ack) begin
                if (hit) begin
                    rdata       <= {gvec, cls_code(sel)};
                    rdata_valid <= 1'b1;
                end else if (chain_en) begin
                    pass_q      <= 1'b1;
                    pass_hw_q   <= hw_ack;
                end else begin
                    rdata       <= {gvec, CODE_W'(0)};
                    rdata_valid <= 1'b1;
                end
            end else if (rd_gvec) begin
                rdata       <= {gvec, CODE_W'(0)};
                rdata_valid <= 1'b1;
            end else if (rd_cfg) begin
                rdata       <= DATA_W'(chain_en);
                rdata_valid <= 1'b1;
            end
        end
    end

    // Chain output falls away the moment the strobe (or, for hardware, ack_in) leaves.
    assign ack_out_n = !(pass_q && !ds_n && (!pass_hw_q || !ack_in_n));

    assert_single_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clr));
    assert_no_stale_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ds_n |-> ack_out_n);
    assert_pass_no_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_out_n |-> !rdata_valid);
    assert_served_when_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_ack && pend != '0) |-> clr != '0);
endmodule

// File: rtl/svc_ack_ctrl.sv
// Top of the service request acknowledge unit.
// Wires the bus decode, the pending flags and the response logic together.
// Assumes request pulses last one cycle and all inputs are synchronous to clk.
module svc_ack_ctrl
    import svc_ack_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              ds_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ack_in_n,
    input  logic              rx_pulse,
    input  logic              tx_pulse,
    input  logic              mdm_pulse,
    output logic              rx_req,
    output logic              tx_req,
    output logic              mdm_req,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_valid,
    output logic              ack_out_n
);
    localparam int GV_W = DATA_W - CODE_W;

    logic             strobe_start, hw_ack, reg_ack, rd_cfg, rd_gvec, chain_en;
    logic [IDX_W-1:0] reg_cls;
    logic [GV_W-1:0]  gvec;
    logic [NCLS-1:0]  set, clr, pend;

    assign set     = {rx_pulse, tx_pulse, mdm_pulse};
    assign rx_req  = pend[CLS_RX];
    assign tx_req  = pend[CLS_TX];
    assign mdm_req = pend[CLS_MDM];

    svc_bus_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ds_n(ds_n), .ack_in_n(ack_in_n),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .strobe_start(strobe_start),
        .hw_ack(hw_ack), .reg_ack(reg_ack), .reg_cls(reg_cls), .rd_cfg(rd_cfg),
        .rd_gvec(rd_gvec), .chain_en(chain_en), .gvec(gvec)
    );

    svc_pend_bank #(.N(NCLS)) u_pend (
        .clk(clk), .rst_n(rst_n), .set(set), .clr(clr), .pend(pend)
    );

    svc_ack_resp #(.N(NCLS), .DATA_W(DATA_W)) u_resp (
        .clk(clk), .rst_n(rst_n), .ds_n(ds_n), .ack_in_n(ack_in_n),
        .strobe_start(strobe_start), .hw_ack(hw_ack), .reg_ack(reg_ack),
        .reg_cls(reg_cls), .rd_cfg(rd_cfg), .rd_gvec(rd_gvec), .chain_en(chain_en),
        .gvec(gvec), .pend(pend), .clr(clr), .rdata(rdata),
        .rdata_valid(rdata_valid), .ack_out_n(ack_out_n)
    );
endmodule

// File: tb/svc_ack_ctrl_test.sv
// Directed bench for svc_ack_ctrl: one task per scenario, each checks its own results.
module svc_ack_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, ds_n = 1'b1, wr_en = 1'b0, ack_in_n = 1'b1;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       rx_pulse = 1'b0, tx_pulse = 1'b0, mdm_pulse = 1'b0;
    logic       rx_req, tx_req, mdm_req, rdata_valid, ack_out_n;
    logic [7:0] rdata;
    int         n_chk = 0, n_fail = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    svc_ack_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ds_n(ds_n), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .ack_in_n(ack_in_n), .rx_pulse(rx_pulse),
        .tx_pulse(tx_pulse), .mdm_pulse(mdm_pulse), .rx_req(rx_req), .tx_req(tx_req),
        .mdm_req(mdm_req), .rdata(rdata), .rdata_valid(rdata_valid), .ack_out_n(ack_out_n)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic bus_begin(input logic c_n, input logic w, input logic [2:0] a,
                             input logic [7:0] d, input logic ai_n);
        @(negedge clk);
        cs_n = c_n; wr_en = w; addr = a; wdata = d; ack_in_n = ai_n; ds_n = 1'b0;
        @(negedge clk);
    endtask

    task automatic bus_end();
        ds_n = 1'b1; ack_in_n = 1'b1; cs_n = 1'b1; wr_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
        bus_begin(1'b0, 1'b1, a, d, 1'b1);
        bus_end();
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [7:0] v, output logic ok);
        bus_begin(1'b0, 1'b0, a, 8'h00, 1'b1);
        v = rdata; ok = rdata_valid;
        bus_end();
    endtask

    task automatic hw_ack(output logic [7:0] v, output logic ok, output logic ao);
        bus_begin(1'b1, 1'b0, 3'd0, 8'h00, 1'b0);
        v = rdata; ok = rdata_valid; ao = ack_out_n;
        bus_end();
    endtask

    task automatic pulse(input logic r, input logic t, input logic m);
        @(negedge clk);
        rx_pulse = r; tx_pulse = t; mdm_pulse = m;
        @(negedge clk);
        rx_pulse = 1'b0; tx_pulse = 1'b0; mdm_pulse = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] v; logic ok;
        chk("R10 reset rx_req", rx_req, 0);
        chk("R10 reset tx_req", tx_req, 0);
        chk("R10 reset mdm_req", mdm_req, 0);
        chk("R10 reset ack_out_n", ack_out_n, 1);
        chk("R5 reset rdata_valid", rdata_valid, 0);
        chk("R5 idle rdata zero", rdata, 0);
        rd_reg(3'd0, v, ok);
        chk("R10 reset vector", {ok, v}, {1'b1, 8'h00});
        rd_reg(3'd1, v, ok);
        chk("R10 reset chain off", {ok, v}, {1'b1, 8'h00});
    endtask

    task automatic t_config();
        logic [7:0] v; logic ok;
        wr_reg(3'd0, 8'hAD);
        rd_reg(3'd0, v, ok);
        chk("R10 vector keeps upper bits", v, 8'hA8);
        wr_reg(3'd1, 8'h01);
        rd_reg(3'd1, v, ok);
        chk("R10 chain enable set", v, 8'h01);
        wr_reg(3'd1, 8'h00);
        rd_reg(3'd1, v, ok);
        chk("R10 chain enable clear", v, 8'h00);
    endtask

    task automatic t_pulses();
        pulse(1'b0, 1'b1, 1'b0);
        chk("R1 tx alone tx_req", tx_req, 1);
        chk("R1 tx alone rx_req", rx_req, 0);
        chk("R1 tx alone mdm_req", mdm_req, 0);
        pulse(1'b1, 1'b0, 1'b1);
        chk("R1 all pending", {rx_req, tx_req, mdm_req}, 3'b111);
    endtask

    task automatic t_reg_ack();
        logic [7:0] v; logic ok;
        rd_reg(3'd3, v, ok);
        chk("R4 R5 tx register ack", {ok, v}, {1'b1, 8'hAA});
        chk("R6 tx cleared others kept", {rx_req, tx_req, mdm_req}, 3'b101);
        rd_reg(3'd2, v, ok);
        chk("R4 R5 rx register ack", {ok, v}, {1'b1, 8'hAB});
        rd_reg(3'd4, v, ok);
        chk("R4 R5 mdm register ack", {ok, v}, {1'b1, 8'hA9});
        chk("R6 all cleared", {rx_req, tx_req, mdm_req}, 3'b000);
        chk("R5 rdata zero after release", {rdata_valid, rdata}, 9'h000);
    endtask

    task automatic t_hw_priority();
        logic [7:0] v; logic ok, ao;
        pulse(1'b1, 1'b1, 1'b1);
        hw_ack(v, ok, ao);
        chk("R3 first serves rx", {ok, ao, v}, {2'b11, 8'hAB});
        hw_ack(v, ok, ao);
        chk("R3 second serves tx", {ok, ao, v}, {2'b11, 8'hAA});
        hw_ack(v, ok, ao);
        chk("R3 third serves mdm", {ok, ao, v}, {2'b11, 8'hA9});
        chk("R6 none left", {rx_req, tx_req, mdm_req}, 3'b000);
    endtask

    task automatic t_cs_low_not_hw();
        pulse(1'b1, 1'b0, 1'b0);
        bus_begin(1'b0, 1'b0, 3'd0, 8'h00, 1'b0);
        chk("R2 cs low is register read", {rdata_valid, rdata}, {1'b1, 8'hA8});
        bus_end();
        chk("R2 rx still pending", rx_req, 1);
    endtask

    task automatic t_same_cycle();
        @(negedge clk);
        cs_n = 1'b0; wr_en = 1'b0; addr = 3'd2; ds_n = 1'b0; rx_pulse = 1'b1;
        @(negedge clk);
        rx_pulse = 1'b0;
        chk("R6 ack vector with new pulse", {rdata_valid, rdata}, {1'b1, 8'hAB});
        chk("R6 new pulse kept pending", rx_req, 1);
        bus_end();
    endtask

    task automatic t_hold();
        bus_begin(1'b0, 1'b0, 3'd2, 8'h00, 1'b1);
        chk("R11 first edge serves rx", {rdata_valid, rdata}, {1'b1, 8'hAB});
        rx_pulse = 1'b1;
        @(negedge clk);
        rx_pulse = 1'b0;
        repeat (3) @(negedge clk);
        chk("R11 held data stable", {rdata_valid, rdata}, {1'b1, 8'hAB});
        chk("R11 request during hold stays", rx_req, 1);
        bus_end();
        chk("R11 still pending after release", rx_req, 1);
        begin
            logic [7:0] v; logic ok;
            rd_reg(3'd2, v, ok);
        end
    endtask

    task automatic t_chain_off_empty();
        logic [7:0] v; logic ok, ao;
        hw_ack(v, ok, ao);
        chk("R8 hw empty zero code", {ok, ao, v}, {2'b11, 8'hA8});
        rd_reg(3'd4, v, ok);
        chk("R8 reg empty zero code", {ok, v}, {1'b1, 8'hA8});
    endtask

    task automatic t_chain_on_empty();
        wr_reg(3'd1, 8'h01);
        bus_begin(1'b1, 1'b0, 3'd0, 8'h00, 1'b0);
        chk("R7 hw empty passes on", {ack_out_n, rdata_valid}, 2'b00);
        @(negedge clk);
        chk("R7 pass held", ack_out_n, 0);
        ack_in_n = 1'b1;
        #1;
        chk("R9 ack_in release drops pass", ack_out_n, 1);
        bus_end();
        bus_begin(1'b0, 1'b0, 3'd3, 8'h00, 1'b1);
        chk("R7 reg empty passes on", {ack_out_n, rdata_valid}, 2'b00);
        ds_n = 1'b1;
        #1;
        chk("R9 strobe release drops pass", ack_out_n, 1);
        bus_end();
        chk("R9 no stale pass", ack_out_n, 1);
    endtask

    task automatic t_chain_on_pending();
        logic [7:0] v; logic ok, ao;
        pulse(1'b0, 1'b0, 1'b1);
        hw_ack(v, ok, ao);
        chk("R7 pending served not passed", {ok, ao, v}, {2'b11, 8'hA9});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_config();
        t_pulses();
        t_reg_ack();
        t_hw_priority();
        t_cs_low_not_hw();
        t_same_cycle();
        t_hold();
        t_chain_off_empty();
        t_chain_on_empty();
        t_chain_on_pending();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule